// File: doc/BRIEF.md
# Interpolating Hit Timestamp Encoder

This block turns the arrival of a hit on any of its channels into a single binary timestamp measured against the reference clock. Each timestamp has three parts. The most significant part is a wrapping count of reference-clock edges. Next comes the index of the fast clock cycle in which the hit fell, where the fast clock runs at 32 cycles per reference period. The least significant part is the position of the hit inside that fast cycle, read from a 32-tap delay line.

The fast clock and the delay line live outside the block. At each hit they present, for the channel that was hit, a 5-bit fast-cycle index and a 32-bit thermometer snapshot of the delay line. Both interpolation stages divide by a power of two. The fine part of the stamp is therefore a 10-bit binary fraction of the reference period, and the block needs no scaling arithmetic.

The channels work independently. Each has its own capture and encode pipeline, so a hit on one channel never delays or disturbs another. Every result is presented with a one-cycle valid pulse at a fixed latency.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: While reset (rstN low) is applied, and immediately after it is released, every tsValid bit is 0 and every tsOut word is 0.
- R2: The coarse field is a 12-bit count of the rising clock edges since reset was released. The edge that captures a hit reads the count as it stood before that edge, and the count wraps from 4095 to 0.
- R3: A channel word is 22 bits wide. Bits 21:10 hold the coarse count, bits 9:5 the fast-cycle index, and bits 4:0 the tap index.
- R4: The tap index is the length of the unbroken run of ones that starts at bit 0 of the channel's thermometer snapshot.
- R5: A zero inside the run of ones (a bubble) ends the count at the first 1-to-0 transition, scanning upward from bit 0. Any ones above that transition are ignored.
- R6: An all-ones snapshot means a full fast cycle has passed. The tap index becomes 0 and the fast-cycle index goes up by one. When the fast index was 31 the carry passes into the coarse field, which itself wraps from 4095 to 0.
- R7: An all-zeros snapshot gives a tap index of 0 and leaves the fast-cycle index unchanged.
- R8: A hit sampled on a channel at edge E produces a tsValid pulse on that channel lasting exactly one cycle. The new word appears together with the pulse, updated at edge E+2.
- R9: Hits on several channels at the same edge each produce that channel's own word. A channel that had no hit shows no valid pulse, and its word does not change.
- R10: Hits on one channel on consecutive edges each produce their own result, on consecutive cycles.
- R11: A channel's tsOut word holds its value between that channel's valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (40 MHz in the target system) |
| rstN | input | 1 | Asynchronous active-low reset |
| hitIn | input | 32 | Per-channel hit strobe, sampled at the rising edge |
| fastSnap | input | 160 | Per-channel 5-bit fast-cycle index; channel c uses bits 5c+4:5c |
| tapSnap | input | 1024 | Per-channel 32-bit thermometer snapshot; channel c uses bits 32c+31:32c |
| tsOut | output | 704 | Per-channel 22-bit timestamp; channel c uses bits 22c+21:22c |
| tsValid | output | 32 | Per-channel one-cycle strobe marking a new timestamp |

## Verification
The assertions take for granted that hitIn is low while reset is held, so that no hit enters a pipeline during reset. They also assume that a channel's snapshots are valid whenever its hit strobe is high. The bench drives every input on the falling edge, keeps hitIn at zero throughout reset, and changes fastSnap and tapSnap only together with a hit. The wrap checks let the free-running coarse count reach 4094 and 4095 on its own, without forcing any internal state.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

  // Per-channel pipeline strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch coarse count and snapshots
    logic decode;    // reduce thermometer code to a run length
    logic present;   // assemble and publish the timestamp
  } chStrobe_t;

endpackage

// File: rtl/tdc_therm_runlen.sv
module tdc_therm_runlen #(
  parameter int TAPS = 32,
  parameter int CNTW = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0] code,
  output logic [CNTW-1:0] runLen
);

  logic stopped;

  // Length of the run of ones starting at bit 0; the first 0 ends it
  always_comb begin
    runLen  = '0;
    stopped = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (!stopped) begin
        if (code[i]) runLen = CNTW'(i + 1);
        else         stopped = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdc_enc_ctrl.sv
module tdc_enc_ctrl
  import tdc_enc_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       hitIn,
  output chStrobe_t [NCH-1:0]  strobes,
  output logic [NCH-1:0]       tsValid
);

  logic [NCH-1:0] decPend;
  logic [NCH-1:0] presPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decPend  <= '0;
      presPend <= '0;
      tsValid  <= '0;
    end else begin
      decPend  <= hitIn;
      presPend <= decPend;
      tsValid  <= presPend;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    assign strobes[c].capture = hitIn[c];
    assign strobes[c].decode  = decPend[c];
    assign strobes[c].present = presPend[c];
  end

endmodule

// File: rtl/tdc_enc_datapath.sv
module tdc_enc_datapath
  import tdc_enc_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int FASTW = 5,
  parameter int TAPS  = 32,
  parameter int CW    = 12,
  parameter int TAPW  = $clog2(TAPS),
  parameter int TSW   = CW + FASTW + TAPW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chStrobe_t [NCH-1:0]   strobes,
  input  logic [NCH*FASTW-1:0]  fastSnap,
  input  logic [NCH*TAPS-1:0]   tapSnap,
  output logic [NCH*TSW-1:0]    tsOut
);

  localparam int CNTW = $clog2(TAPS + 1);
  localparam int BASEW = CW + FASTW;

  logic [CW-1:0] coarseCnt;

  // Free-running wrapping count of reference edges, shared by all channels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coarseCnt <= '0;
    else       coarseCnt <= coarseCnt + 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CW-1:0]    capCoarse;
    logic [FASTW-1:0] capFast;
    logic [TAPS-1:0]  capTap;
    logic [CNTW-1:0]  runLen;
    logic [BASEW-1:0] decBase;
    logic [CNTW-1:0]  decCount;
    logic [TSW-1:0]   tsReg;

    tdc_therm_runlen #(.TAPS(TAPS), .CNTW(CNTW)) i_runlen (
      .code   (capTap),
      .runLen (runLen)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capCoarse <= '0;
        capFast   <= '0;
        capTap    <= '0;
        decBase   <= '0;
        decCount  <= '0;
        tsReg     <= '0;
      end else begin
        if (strobes[c].capture) begin
          capCoarse <= coarseCnt;
          capFast   <= fastSnap[c*FASTW +: FASTW];
          capTap    <= tapSnap[c*TAPS +: TAPS];
        end
        if (strobes[c].decode) begin
          decBase  <= {capCoarse, capFast};
          decCount <= runLen;
        end
        if (strobes[c].present) begin
          // A full run (count == TAPS) carries into the fast index and beyond
          tsReg <= {decBase, {TAPW{1'b0}}} + TSW'(decCount);
        end
      end
    end

    assign tsOut[c*TSW +: TSW] = tsReg;
  end

endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder
  import tdc_enc_pkg::*;
#(
  parameter int  NCH          = 32,
  parameter int  FAST_PER_REF = 32,
  parameter int  TAPS         = 32,
  parameter int  CW           = 12,
  localparam int FASTW        = $clog2(FAST_PER_REF),
  localparam int TAPW         = $clog2(TAPS),
  localparam int TSW          = CW + FASTW + TAPW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        hitIn,
  input  logic [NCH*FASTW-1:0]  fastSnap,
  input  logic [NCH*TAPS-1:0]   tapSnap,
  output logic [NCH*TSW-1:0]    tsOut,
  output logic [NCH-1:0]        tsValid
);

  chStrobe_t [NCH-1:0] strobes;

  tdc_enc_ctrl #(.NCH(NCH)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hitIn   (hitIn),
    .strobes (strobes),
    .tsValid (tsValid)
  );

  tdc_enc_datapath #(
    .NCH(NCH), .FASTW(FASTW), .TAPS(TAPS), .CW(CW), .TAPW(TAPW), .TSW(TSW)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fastSnap (fastSnap),
    .tapSnap  (tapSnap),
    .tsOut    (tsOut)
  );

endmodule

// File: rtl/tdc_enc_checker.sv
module tdc_enc_checker #(
  parameter int NCH = 32,
  parameter int TSW = 22
) (
  input logic               clk,
  input logic               rstN,
  input logic [NCH-1:0]     hitIn,
  input logic [NCH-1:0]     tsValid,
  input logic [NCH*TSW-1:0] tsOut
);

  // R1: valid outputs are cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> (tsValid == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8: each hit yields a valid pulse at fixed latency
    a_r8_hit_to_valid: assert property (@(posedge clk) disable iff (!rstN)
      hitIn[c] |-> ##3 tsValid[c]);

    // R8, R9: no valid pulse without a matching hit
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
      tsValid[c] |-> $past(hitIn[c], 3));

    // R11: word is held while no new result is published
    a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
      !tsValid[c] |-> $stable(tsOut[c*TSW +: TSW]));
  end

endmodule

bind tdc_stamp_encoder tdc_enc_checker #(.NCH(NCH), .TSW(TSW)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hitIn   (hitIn),
  .tsValid (tsValid),
  .tsOut   (tsOut)
);

// File: tb/test_tdc_stamp_encoder.sv
module test_tdc_stamp_encoder;

  localparam int NCH = 32;
  localparam int FW  = 5;
  localparam int TP  = 32;
  localparam int TSW = 22;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NCH-1:0]     hitIn = '0;
  logic [NCH*FW-1:0]  fastSnap;
  logic [NCH*TP-1:0]  tapSnap;
  logic [NCH*TSW-1:0] tsOut;
  logic [NCH-1:0]     tsValid;

  logic [FW-1:0] fastArr [NCH];
  logic [TP-1:0] tapArr  [NCH];
  logic [11:0]   refCount;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      fastSnap[c*FW +: FW] = fastArr[c];
      tapSnap[c*TP +: TP]  = tapArr[c];
    end
  end

  // Bench's own edge count since reset release (R2)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) refCount <= '0;
    else       refCount <= refCount + 12'd1;
  end

  tdc_stamp_encoder i_tdc_stamp_encoder (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .fastSnap(fastSnap),
    .tapSnap(tapSnap), .tsOut(tsOut), .tsValid(tsValid)
  );

  function automatic logic [TSW-1:0] expTs(input logic [11:0] co, input logic [4:0] fa,
                                           input logic [31:0] tap);
    int n = 0;
    bit stop = 0;
    for (int i = 0; i < 32; i++) begin
      if (!stop) begin
        if (tap[i]) n = i + 1;
        else        stop = 1;
      end
    end
    return {co, fa, 5'd0} + TSW'(n);
  endfunction

  function automatic logic [TSW-1:0] getTs(input int ch);
    return tsOut[ch*TSW +: TSW];
  endfunction

  task automatic check(input bit ok, input string req, input logic [TSW-1:0] act,
                       input logic [TSW-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a hit on one channel at the current falling edge; returns expected word
  task automatic fire(input int ch, input logic [4:0] fa, input logic [31:0] tap,
                      output logic [TSW-1:0] e);
    fastArr[ch] = fa;
    tapArr[ch]  = tap;
    hitIn[ch]   = 1'b1;
    e = expTs(refCount, fa, tap);
  endtask

  task automatic singleHit(input int ch, input logic [4:0] fa, input logic [31:0] tap,
                           input string req);
    logic [TSW-1:0] e;
    fire(ch, fa, tap, e);
    @(negedge clk); hitIn = '0;
    @(negedge clk);
    check(tsValid[ch] == 1'b0, {req, " early valid"}, TSW'(tsValid[ch]), 0);
    @(negedge clk);
    check(tsValid[ch] == 1'b1 && getTs(ch) == e, req, getTs(ch), e);
    @(negedge clk);
    check(tsValid[ch] == 1'b0, "R8 pulse width", TSW'(tsValid[ch]), 0);
  endtask

  task automatic t_reset();
    check(tsValid == '0, "R1 valid in reset", TSW'(tsValid), 0);
    check(tsOut == '0, "R1 words in reset", getTs(0), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(tsValid == '0 && tsOut == '0, "R1 after release", getTs(0), 0);
  endtask

  task automatic t_basic();
    singleHit(0, 5'd3,  32'h0000_0007, "R3 R4 run of three");
    singleHit(0, 5'd17, 32'h00FF_FFFF, "R2 R4 run of 24");
    singleHit(5, 5'd31, 32'h7FFF_FFFF, "R4 run of 31");
  endtask

  task automatic t_bubble();
    singleHit(2, 5'd9,  32'h0000_00F7, "R5 bubble at bit 3");
    singleHit(2, 5'd12, 32'hFFFF_FFFE, "R5 zero at bit 0");
  endtask

  task automatic t_edges();
    singleHit(1, 5'd5,  32'hFFFF_FFFF, "R6 all ones fast+1");
    singleHit(1, 5'd31, 32'hFFFF_FFFF, "R6 all ones carry coarse");
    singleHit(1, 5'd8,  32'h0000_0000, "R7 all zeros");
  endtask

  task automatic t_multi();
    logic [TSW-1:0] e3, e17, e31, held;
    held = getTs(4);
    fire(3,  5'd1,  32'h0000_000F, e3);
    fire(17, 5'd20, 32'h0000_FFFF, e17);
    fire(31, 5'd30, 32'hFFFF_FFFF, e31);
    @(negedge clk); hitIn = '0;
    @(negedge clk);
    @(negedge clk);
    check(getTs(3) == e3 && tsValid[3], "R9 channel 3", getTs(3), e3);
    check(getTs(17) == e17 && tsValid[17], "R9 channel 17", getTs(17), e17);
    check(getTs(31) == e31 && tsValid[31], "R9 channel 31", getTs(31), e31);
    check(!tsValid[4] && getTs(4) == held, "R9 idle channel 4", getTs(4), held);
  endtask

  task automatic t_backToBack();
    logic [TSW-1:0] e [3];
    fire(7, 5'd2, 32'h0000_0001, e[0]);
    @(negedge clk);
    fire(7, 5'd4, 32'h0000_0003, e[1]);
    @(negedge clk);
    fire(7, 5'd6, 32'h0000_0007, e[2]);
    @(negedge clk); hitIn = '0;
    check(tsValid[7] && getTs(7) == e[0], "R10 first", getTs(7), e[0]);
    @(negedge clk);
    check(tsValid[7] && getTs(7) == e[1], "R10 second", getTs(7), e[1]);
    @(negedge clk);
    check(tsValid[7] && getTs(7) == e[2], "R10 third", getTs(7), e[2]);
  endtask

  task automatic t_hold();
    logic [TSW-1:0] held;
    held = getTs(7);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!tsValid[7] && getTs(7) == held, "R11 hold", getTs(7), held);
    end
  endtask

  task automatic t_wrap();
    while (refCount != 12'd4093) @(negedge clk);
    // Hit at 4093 spans 4 negedges, so the next hit lands at count 4097 mod 4096
    singleHit(9, 5'd31, 32'hFFFF_FFFF, "R6 carry to 4094");
    singleHit(9, 5'd31, 32'hFFFF_FFFF, "R2 R6 coarse wrap");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      fastArr[c] = '0;
      tapArr[c]  = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_bubble();
    t_edges();
    t_multi();
    t_backToBack();
    t_hold();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule